// File: doc/BRIEF.md
# Prioritised Multi-Type Trigger Prescaler

This block sits behind the event-selection algorithms of a trigger system. Every clock it receives one condition flag per trigger type (up to 32 types). Each type has its own prescale divider, so that calibration and monitoring selections can be recorded at a reduced, programmable fraction of their raw rate. Among the types whose flags survive prescaling in a given cycle, a fixed-priority selector picks one. It then issues a one-cycle accept pulse together with the index of the winning type.

Prescale factors are written through a simple register write port before a run begins. A run-start pulse re-aligns all dividers and zeroes the statistics. An inhibit input, for example driven while acquisition is busy, suppresses accepts. A free-running raw-rate counter per type keeps normalisation data. Any one of these counters can be read through a combinational select port.

Top module: `trigPrescaler`

## Requirements
- R1: After reset, accept and typeCode are 0, every rate counter reads 0 and every prescale factor is 1, so each flag passes.
- R2: accept and typeCode are registered. They reflect the flags sampled at the previous rising clock edge. When accept is 0, typeCode is 0.
- R3: When several types pass prescaling in the same cycle, the one with the lowest index wins. Index 0 has the highest priority.
- R4: A type with prescale factor N (N ≥ 1) passes its Nth, 2Nth, 3Nth… counted occurrence. An occurrence is counted only in a cycle with inhibit low and runStart low.
- R5: A prescale factor of 0 disables its type. That type never wins, and lower-priority types may win in its place.
- R6: While inhibit is high, no accept is produced in the following cycle and no prescale counter advances.
- R7: Each rate counter counts every cycle in which its flag is high and runStart is low. This includes cycles that are inhibited, prescaled away or disabled.
- R8: Rate counters saturate at their all-ones value and stay there.
- R9: A runStart pulse clears all prescale and rate counters. Flags present in that cycle are neither counted nor accepted.
- R10: Writing a prescale factor (cfgWrEn high, type index on cfgAddr, factor on cfgData) also restarts that type's prescale count from zero.
- R11: rateOut shows, combinationally, the rate counter of the type selected by rateSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| runStart | input | 1 | Single-cycle pulse clearing prescale and rate counters |
| inhibit | input | 1 | Blocks accepts and freezes prescale counters |
| flags | input | NUM_TYPES | Trigger-condition flag per type |
| cfgWrEn | input | 1 | Prescale factor write strobe |
| cfgAddr | input | TYPE_W | Type whose factor is written |
| cfgData | input | PS_W | New prescale factor |
| rateSel | input | TYPE_W | Type whose rate counter is shown on rateOut |
| rateOut | output | CNT_W | Selected rate counter value |
| accept | output | 1 | One-cycle accept pulse |
| typeCode | output | TYPE_W | Index of the accepted type |

## Verification
The accept pulse and type code are due exactly one rising edge after the flags that cause them. The bench therefore drives each flag pattern at a falling edge and compares at the next falling edge. It uses a reference model that is stepped once per driven cycle. A rate counter includes a cycle's flag from the edge that ends that cycle, and rateOut follows rateSel with no register. Rate checks therefore set rateSel in the low clock phase and compare shortly after, before the next edge. A factor write takes effect at the edge that ends its cycle. No flags are driven during that cycle, and the idle output that follows is checked.

// File: rtl/trigPkg.sv
package trigPkg;

  // Strobes from the control module to every datapath lane
  typedef struct packed {
    logic clearRun;   // zero prescale and rate counters
    logic advanceEn;  // prescale counters may step and produce a pass
    logic countEn;    // rate counters may count
    logic cfgWr;      // a factor write is in progress
  } laneCtrl_t;

endpackage

// File: rtl/trigLane.sv
module trigLane
  import trigPkg::*;
#(
  parameter int PS_W  = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  laneCtrl_t        ctrl,
  input  logic             flag,
  input  logic             wrSel,
  input  logic [PS_W-1:0]  cfgData,
  output logic             pass,
  output logic [CNT_W-1:0] rateCnt
);

  localparam logic [CNT_W-1:0] RATE_MAX = '1;
  localparam logic [PS_W-1:0]  FACTOR_RST = PS_W'(1);

  logic [PS_W-1:0] factor;
  logic [PS_W-1:0] psCnt;
  logic            enabled;
  logic            step;
  logic            hit;

  assign enabled = (factor != '0);
  assign step    = ctrl.advanceEn && flag && enabled;
  assign hit     = (psCnt == factor - PS_W'(1));
  assign pass    = step && hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      factor <= FACTOR_RST;
    end else if (ctrl.cfgWr && wrSel) begin
      factor <= cfgData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt <= '0;
    end else if (ctrl.clearRun || (ctrl.cfgWr && wrSel)) begin
      psCnt <= '0;
    end else if (step) begin
      psCnt <= hit ? '0 : psCnt + PS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateCnt <= '0;
    end else if (ctrl.clearRun) begin
      rateCnt <= '0;
    end else if (ctrl.countEn && flag && (rateCnt != RATE_MAX)) begin
      rateCnt <= rateCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/trigDatapath.sv
module trigDatapath
  import trigPkg::*;
#(
  parameter int NUM_TYPES = 32,
  parameter int PS_W      = 16,
  parameter int CNT_W     = 32,
  localparam int TYPE_W   = $clog2(NUM_TYPES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  laneCtrl_t            ctrl,
  input  logic [NUM_TYPES-1:0] flags,
  input  logic [TYPE_W-1:0]    cfgAddr,
  input  logic [PS_W-1:0]      cfgData,
  input  logic [TYPE_W-1:0]    rateSel,
  output logic [NUM_TYPES-1:0] passVec,
  output logic [CNT_W-1:0]     rateOut
);

  logic [CNT_W-1:0] rateArr [NUM_TYPES];

  for (genvar g = 0; g < NUM_TYPES; g++) begin : gLane
    logic wrSel;
    assign wrSel = (cfgAddr == TYPE_W'(g));

    trigLane #(
      .PS_W  (PS_W),
      .CNT_W (CNT_W)
    ) u_lane (
      .clk     (clk),
      .rstN    (rstN),
      .ctrl    (ctrl),
      .flag    (flags[g]),
      .wrSel   (wrSel),
      .cfgData (cfgData),
      .pass    (passVec[g]),
      .rateCnt (rateArr[g])
    );
  end

  assign rateOut = rateArr[rateSel];

endmodule

// File: rtl/trigCtrl.sv
module trigCtrl
  import trigPkg::*;
#(
  parameter int NUM_TYPES = 32,
  localparam int TYPE_W   = $clog2(NUM_TYPES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 runStart,
  input  logic                 inhibit,
  input  logic                 cfgWrEn,
  input  logic [NUM_TYPES-1:0] passVec,
  output laneCtrl_t            ctrl,
  output logic                 accept,
  output logic [TYPE_W-1:0]    typeCode
);

  logic              anyPass;
  logic [TYPE_W-1:0] winner;

  always_comb begin
    ctrl           = '0;
    ctrl.clearRun  = runStart;
    ctrl.advanceEn = !runStart && !inhibit;
    ctrl.countEn   = !runStart;
    ctrl.cfgWr     = cfgWrEn;
  end

  // lowest index wins: scan downwards so the last match is the smallest
  always_comb begin
    winner = '0;
    for (int i = NUM_TYPES - 1; i >= 0; i--) begin
      if (passVec[i]) winner = TYPE_W'(i);
    end
  end

  assign anyPass = |passVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accept   <= 1'b0;
      typeCode <= '0;
    end else begin
      accept   <= anyPass;
      typeCode <= anyPass ? winner : '0;
    end
  end

endmodule

// File: rtl/trigPrescaler.sv
module trigPrescaler
  import trigPkg::*;
#(
  parameter int NUM_TYPES = 32,
  parameter int PS_W      = 16,
  parameter int CNT_W     = 32,
  localparam int TYPE_W   = $clog2(NUM_TYPES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 runStart,
  input  logic                 inhibit,
  input  logic [NUM_TYPES-1:0] flags,
  input  logic                 cfgWrEn,
  input  logic [TYPE_W-1:0]    cfgAddr,
  input  logic [PS_W-1:0]      cfgData,
  input  logic [TYPE_W-1:0]    rateSel,
  output logic [CNT_W-1:0]     rateOut,
  output logic                 accept,
  output logic [TYPE_W-1:0]    typeCode
);

  laneCtrl_t            ctrl;
  logic [NUM_TYPES-1:0] passVec;

  trigCtrl #(
    .NUM_TYPES (NUM_TYPES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .runStart (runStart),
    .inhibit  (inhibit),
    .cfgWrEn  (cfgWrEn),
    .passVec  (passVec),
    .ctrl     (ctrl),
    .accept   (accept),
    .typeCode (typeCode)
  );

  trigDatapath #(
    .NUM_TYPES (NUM_TYPES),
    .PS_W      (PS_W),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .flags   (flags),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .rateSel (rateSel),
    .passVec (passVec),
    .rateOut (rateOut)
  );

endmodule

// File: rtl/trigPrescalerChk.sv
module trigPrescalerChk #(
  parameter int NUM_TYPES = 32,
  parameter int CNT_W     = 32,
  localparam int TYPE_W   = $clog2(NUM_TYPES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 runStart,
  input logic                 inhibit,
  input logic [NUM_TYPES-1:0] flags,
  input logic [TYPE_W-1:0]    rateSel,
  input logic [CNT_W-1:0]     rateOut,
  input logic                 accept,
  input logic [TYPE_W-1:0]    typeCode
);

  localparam logic [CNT_W-1:0] RATE_MAX = '1;

  logic [NUM_TYPES-1:0] prevFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevFlags <= '0;
    else       prevFlags <= flags;
  end

  // R6
  inhibit_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    inhibit |=> !accept);

  // R9
  runstart_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    runStart |=> !accept);

  // R2
  no_flag_no_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags == '0) |=> !accept);

  // R2
  idle_code_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accept |-> (typeCode == '0));

  // R3
  winner_flagged_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> prevFlags[typeCode]);

  // R8
  rate_saturates_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rateOut == RATE_MAX) && !runStart |=> ($stable(rateSel) -> (rateOut == RATE_MAX)));

  // R7
  rate_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runStart |=> ($stable(rateSel) ->
      ((rateOut == $past(rateOut)) || (rateOut == $past(rateOut) + CNT_W'(1)))));

endmodule

bind trigPrescaler trigPrescalerChk #(
  .NUM_TYPES (NUM_TYPES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .runStart (runStart),
  .inhibit  (inhibit),
  .flags    (flags),
  .rateSel  (rateSel),
  .rateOut  (rateOut),
  .accept   (accept),
  .typeCode (typeCode)
);

// File: tb/trigPrescaler_tb.sv
module trigPrescaler_tb;

  localparam int NT = 32;
  localparam int TW = 5;
  localparam int PW = 16;
  localparam int CW = 8;
  localparam int unsigned RMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN;
  logic          runStart;
  logic          inhibit;
  logic [NT-1:0] flags;
  logic          cfgWrEn;
  logic [TW-1:0] cfgAddr;
  logic [PW-1:0] cfgData;
  logic [TW-1:0] rateSel;
  logic [CW-1:0] rateOut;
  logic          accept;
  logic [TW-1:0] typeCode;

  always #10 clk = ~clk;

  trigPrescaler #(
    .NUM_TYPES (NT),
    .PS_W      (PW),
    .CNT_W     (CW)
  ) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .runStart (runStart),
    .inhibit  (inhibit),
    .flags    (flags),
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .rateSel  (rateSel),
    .rateOut  (rateOut),
    .accept   (accept),
    .typeCode (typeCode)
  );

  int vecCnt = 0;
  int errCnt = 0;

  int unsigned factorM [NT];
  int unsigned psM     [NT];
  int unsigned rateM   [NT];
  logic          expAcc;
  logic [TW-1:0] expCode;

  function automatic void modelInit();
    for (int i = 0; i < NT; i++) begin
      factorM[i] = 1; psM[i] = 0; rateM[i] = 0;
    end
    expAcc = 1'b0; expCode = '0;
  endfunction

  function automatic void modelStep(logic [NT-1:0] f, logic inh, logic rs);
    logic [NT-1:0] passM;
    passM = '0;
    if (rs) begin
      for (int i = 0; i < NT; i++) begin psM[i] = 0; rateM[i] = 0; end
    end else begin
      for (int i = 0; i < NT; i++) begin
        if (f[i]) begin
          if (rateM[i] < RMAX) rateM[i]++;
          if (!inh && factorM[i] != 0) begin
            if (psM[i] == factorM[i] - 1) begin passM[i] = 1'b1; psM[i] = 0; end
            else psM[i]++;
          end
        end
      end
    end
    expAcc = |passM;
    expCode = '0;
    for (int i = NT - 1; i >= 0; i--) if (passM[i]) expCode = TW'(i);
  endfunction

  task automatic checkOut(string tag);
    vecCnt++;
    if (accept !== expAcc || typeCode !== expCode) begin
      errCnt++;
      $display("FAIL %s: accept/typeCode got %0b/%0d expected %0b/%0d",
               tag, accept, typeCode, expAcc, expCode);
    end
  endtask

  task automatic cycle(logic [NT-1:0] f, logic inh, logic rs, string tag);
    flags = f; inhibit = inh; runStart = rs;
    modelStep(f, inh, rs);
    @(posedge clk); @(negedge clk);
    flags = '0; inhibit = 1'b0; runStart = 1'b0;
    checkOut(tag);
  endtask

  task automatic cfgWrite(int unsigned addr, int unsigned data, string tag);
    cfgWrEn = 1'b1; cfgAddr = TW'(addr); cfgData = PW'(data);
    factorM[addr] = data; psM[addr] = 0;
    expAcc = 1'b0; expCode = '0;
    @(posedge clk); @(negedge clk);
    cfgWrEn = 1'b0;
    checkOut(tag);
  endtask

  task automatic checkRate(int unsigned sel, string tag);
    rateSel = TW'(sel);
    #1;
    vecCnt++;
    if (rateOut !== CW'(rateM[sel])) begin
      errCnt++;
      $display("FAIL %s: rate[%0d] got %0d expected %0d", tag, sel, rateOut, rateM[sel]);
    end
  endtask

  initial begin
    #(20 * 150000);
    errCnt++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    int unsigned seedDummy;
    rstN = 1'b0; runStart = 1'b0; inhibit = 1'b0; flags = '0;
    cfgWrEn = 1'b0; cfgAddr = '0; cfgData = '0; rateSel = '0;
    modelInit();
    seedDummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkOut("R1 reset outputs");
    checkRate(0, "R1 reset rate");
    checkRate(31, "R1 reset rate");
    cycle(NT'(32'h0000_0020), 1'b0, 1'b0, "R1 default factor passes type 5");

    // R2 single flag, result next cycle
    cycle(NT'(32'h8000_0000), 1'b0, 1'b0, "R2 lowest-priority alone");
    cycle('0, 1'b0, 1'b0, "R2 idle after accept");

    // R3 priority
    cycle(NT'(32'h8000_0100), 1'b0, 1'b0, "R3 lowest index wins");
    cycle('1, 1'b0, 1'b0, "R3 all flags -> type 0");

    // R4 divide by 3 on type 3
    cfgWrite(3, 3, "R4 write factor");
    for (int k = 0; k < 6; k++) cycle(NT'(32'h0000_0008), 1'b0, 1'b0, "R4 every third");

    // R5 disabled type 2 yields to type 7
    cfgWrite(2, 0, "R5 write factor 0");
    cycle(NT'(32'h0000_0084), 1'b0, 1'b0, "R5 disabled type skipped");
    cycle(NT'(32'h0000_0004), 1'b0, 1'b0, "R5 disabled alone no accept");

    // R6 inhibit freezes prescale counters
    cycle('1, 1'b1, 1'b0, "R6 inhibit all flags");
    cycle(NT'(32'h0000_0008), 1'b1, 1'b0, "R6 inhibited type 3");
    cycle(NT'(32'h0000_0008), 1'b1, 1'b0, "R6 inhibited type 3");
    cycle(NT'(32'h0000_0008), 1'b0, 1'b0, "R6 first counted after inhibit");

    // R7 raw rates
    checkRate(2, "R7 disabled type still counted");
    checkRate(3, "R7 prescaled and inhibited counted");

    // R10 write restarts divider
    cycle(NT'(32'h0000_0008), 1'b0, 1'b0, "R10 pre-write count");
    cfgWrite(3, 3, "R10 rewrite factor");
    cycle(NT'(32'h0000_0008), 1'b0, 1'b0, "R10 count restarted");
    cycle(NT'(32'h0000_0008), 1'b0, 1'b0, "R10 count restarted");
    cycle(NT'(32'h0000_0008), 1'b0, 1'b0, "R10 third after rewrite");

    // R9 run start
    cycle('1, 1'b0, 1'b1, "R9 run start blocks accept");
    checkRate(0, "R9 rate cleared");
    checkRate(3, "R9 rate cleared");
    cycle(NT'(32'h0000_0008), 1'b0, 1'b0, "R9 prescale cleared");

    // R8 saturation on type 9
    for (int k = 0; k < 300; k++) cycle(NT'(32'h0000_0200), 1'b1, 1'b0, "R8 inhibited burst");
    checkRate(9, "R8 saturated");
    cycle(NT'(32'h0000_0200), 1'b0, 1'b0, "R8 flag after saturation");
    checkRate(9, "R8 stays saturated");

    // R11 select sweep
    for (int s = 0; s < NT; s++) checkRate(s, "R11 select sweep");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [NT-1:0] f;
      logic inh, rs;
      if (n % 128 == 0) cfgWrite($urandom % NT, $urandom % 5, "R4/R10 random write");
      f = NT'($urandom & $urandom & $urandom);
      inh = ($urandom % 8 == 0);
      rs = ($urandom % 251 == 0);
      cycle(f, inh, rs, "R2/R3/R4/R5/R6 random");
      if (n % 16 == 0) checkRate($urandom % NT, "R7/R11 random rate");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule